// File: doc/BRIEF.md
# Absolute-Error Fitness Scorer

This block grades a candidate circuit during an evolutionary search. It takes two pixel streams: the candidate's output, and a reference. The reference may come from a stored target image or from a fault-free twin of the same circuit, which is how a damaged copy is trained to imitate a healthy one. For each matched pair of pixels the block takes the absolute difference and adds it to a frame total. When the frame ends, the total is latched as the fitness score for the processor. A lower score is better, and the processor keeps the candidate with the smallest value.

Two indications come with each latched score. A match flag goes high when the score is exactly zero, which means the candidate reproduces its reference. An alarm flag goes high when the score is greater than a programmable limit, which tells the processor to grow the array. Both flags and the done indication are derived only from the latched score. They stay set until the processor acknowledges the read.

Both pixel inputs are valid/ready streams joined into a single consumer. The block raises `cand_ready` and `ref_ready` together, and only in a cycle where both valids are high, a frame is open and no start is present. A pixel therefore moves only when its partner moves in the same cycle. A source may hold its valid high for as long as it needs, and ready may depend on valid. Outside a frame, both readies stay low.

Top module: `sae_fitness_eval`

## Requirements
- R1: After reset, `done`, `recovered`, `exceed`, `fitness` (all zero) and both readies are low.
- R2: A beat is consumed only in a cycle where a frame is open, `start` is low and both valids are high. In that cycle both readies are high. Outside an open frame, both readies are low.
- R3: Each consumed beat adds |cand_pix - ref_pix| (unsigned 8-bit) to the frame total.
- R4: The frame total saturates at 2^ACC_W-1 and never wraps.
- R5: A `start` pulse clears the running total and opens a new frame, even if a frame is already in progress. No beat is consumed in the start cycle.
- R6: The beat that carries `cand_last=1` is included in the total. After the edge that consumes it, `fitness` shows the total, `done` is 1 and the frame is closed (readies low).
- R7: `done` and `fitness` hold until a `result_rd` pulse. The read clears `done`, `recovered` and `exceed` and leaves `fitness` unchanged.
- R8: `recovered` is 1 exactly when a latched, unread result equals zero.
- R9: `exceed` is 1 exactly when a latched, unread result is strictly greater than the `threshold` value present at frame end.
- R10: The flags are never driven by a partial sum. During a frame they keep their prior value. A new frame end overwrites `fitness` and the flags even if the previous result was not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a frame and clears the running total |
| cand_valid | input | 1 | Candidate pixel valid |
| cand_ready | output | 1 | Candidate pixel accepted |
| cand_pix | input | PIX_W | Candidate output pixel |
| cand_last | input | 1 | Marks the final pixel of the frame |
| ref_valid | input | 1 | Reference pixel valid |
| ref_ready | output | 1 | Reference pixel accepted |
| ref_pix | input | PIX_W | Reference pixel |
| threshold | input | ACC_W | Alarm limit compared at frame end |
| result_rd | input | 1 | Acknowledges the latched result |
| fitness | output | ACC_W | Latched sum of absolute errors |
| done | output | 1 | A latched result is waiting to be read |
| recovered | output | 1 | Latched result is zero |
| exceed | output | 1 | Latched result is above the threshold |

## Verification
The hardest behaviour to reach from the ports is saturation, because a 32-bit total needs millions of worst-case pixels. The bench therefore runs a second copy of the block with a 10-bit accumulator on the same inputs. Frames of maximum-difference pixels push that copy past its ceiling, while the wide copy gives the exact total. The bench also drives randomly gapped valids on both sides, opens frames that are abandoned mid-stream by a fresh start, and ends frames without reading the previous result. These cover the join rules, the clearing rule and the overwrite rule.

// File: rtl/sae_pkg.sv
`timescale 1ns/1ps
package sae_pkg;
  localparam int unsigned SAE_PIX_W = 8;
  localparam int unsigned SAE_ACC_W = 32;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_state_t;
endpackage

// File: rtl/sae_absdiff.sv
`timescale 1ns/1ps
module sae_absdiff #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] d
);
  always_comb begin
    if (a >= b) d = a - b;
    else        d = b - a;
  end
endmodule

// File: rtl/sae_accum.sv
`timescale 1ns/1ps
module sae_accum #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [PIX_W-1:0] diff,
  output logic [ACC_W-1:0] sum_next,
  output logic [ACC_W-1:0] sum
);
  localparam int unsigned PAD_W = ACC_W + 1 - PIX_W;

  logic [ACC_W:0] wide;

  // One extra bit catches the carry; on carry the total pins at all ones.
  always_comb begin
    wide = {1'b0, sum} + {{PAD_W{1'b0}}, diff};
    if (clr)             sum_next = '0;
    else if (!add_en)    sum_next = sum;
    else if (wide[ACC_W]) sum_next = '1;
    else                 sum_next = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= '0;
    else        sum <= sum_next;
  end

  // Without a clear the total never decreases (no wrap) - R3, R4
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (sum >= $past(sum)));

  // A clear empties the total on the next edge - R5
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0));
endmodule

// File: rtl/sae_result.sv
`timescale 1ns/1ps
module sae_result #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [ACC_W-1:0] value,
  input  logic [ACC_W-1:0] threshold,
  input  logic             rd,
  output logic [ACC_W-1:0] fitness,
  output logic             done,
  output logic             recovered,
  output logic             exceed
);
  // A frame end wins over a read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fitness   <= '0;
      done      <= 1'b0;
      recovered <= 1'b0;
      exceed    <= 1'b0;
    end else if (capture) begin
      fitness   <= value;
      done      <= 1'b1;
      recovered <= (value == '0);
      exceed    <= (value > threshold);
    end else if (rd && done) begin
      done      <= 1'b0;
      recovered <= 1'b0;
      exceed    <= 1'b0;
    end
  end

  assert_match_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recovered |-> (done && fitness == '0));

  assert_alarm_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exceed |-> done);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd && !capture) |=> (done && $stable(fitness)));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !rd |=> ($stable(recovered) && $stable(exceed)));
endmodule

// File: rtl/sae_fitness_eval.sv
`timescale 1ns/1ps
module sae_fitness_eval
  import sae_pkg::*;
#(
  parameter int unsigned PIX_W = SAE_PIX_W,
  parameter int unsigned ACC_W = SAE_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cand_valid,
  output logic             cand_ready,
  input  logic [PIX_W-1:0] cand_pix,
  input  logic             cand_last,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic [ACC_W-1:0] threshold,
  input  logic             result_rd,
  output logic [ACC_W-1:0] fitness,
  output logic             done,
  output logic             recovered,
  output logic             exceed
);
  frame_state_t     st;
  logic             beat;
  logic             frame_end;
  logic [PIX_W-1:0] diff;
  logic [ACC_W-1:0] total_next;
  logic [ACC_W-1:0] total;

  // Joined handshake: both sides move together or neither moves.
  assign beat       = (st == FR_RUN) && !start && cand_valid && ref_valid;
  assign frame_end  = beat && cand_last;
  assign cand_ready = beat;
  assign ref_ready  = beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st <= FR_IDLE;
    else if (start)     st <= FR_RUN;
    else if (frame_end) st <= FR_IDLE;
  end

  sae_absdiff #(.PIX_W(PIX_W)) u_diff (
    .a (cand_pix),
    .b (ref_pix),
    .d (diff)
  );

  sae_accum #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .add_en   (beat),
    .diff     (diff),
    .sum_next (total_next),
    .sum      (total)
  );

  sae_result #(.ACC_W(ACC_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (frame_end),
    .value     (total_next),
    .threshold (threshold),
    .rd        (result_rd),
    .fitness   (fitness),
    .done      (done),
    .recovered (recovered),
    .exceed    (exceed)
  );

  assert_join_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_ready || ref_ready) |-> (cand_valid && ref_valid && !start));

  assert_closed_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!cand_ready && done));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(recovered && exceed));

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (total == '0));
endmodule

// File: tb/sae_fitness_eval_tb.sv
`timescale 1ns/1ps
module sae_fitness_eval_tb_top;
  localparam int unsigned PW  = 8;
  localparam int unsigned AW  = 32;
  localparam int unsigned AWS = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, cand_valid, cand_last, ref_valid, result_rd;
  logic [PW-1:0] cand_pix, ref_pix;
  logic [AW-1:0] threshold;
  logic          cand_ready, ref_ready, done, recovered, exceed;
  logic [AW-1:0] fitness;
  logic          s_cr, s_rr, s_done, s_rec, s_exc;
  logic [AWS-1:0] s_fit;
  logic [AWS-1:0] s_thr;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  longint esum;

  always #5 clk = ~clk;
  assign s_thr = threshold[AWS-1:0];

  sae_fitness_eval #(.PIX_W(PW), .ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_pix(cand_pix), .cand_last(cand_last),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_pix(ref_pix),
    .threshold(threshold), .result_rd(result_rd),
    .fitness(fitness), .done(done), .recovered(recovered), .exceed(exceed));

  sae_fitness_eval #(.PIX_W(PW), .ACC_W(AWS)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_valid(cand_valid), .cand_ready(s_cr), .cand_pix(cand_pix), .cand_last(cand_last),
    .ref_valid(ref_valid), .ref_ready(s_rr), .ref_pix(ref_pix),
    .threshold(s_thr), .result_rd(result_rd),
    .fitness(s_fit), .done(s_done), .recovered(s_rec), .exceed(s_exc));

  function automatic longint sat_to(longint v, int w);
    longint mx = (longint'(1) << w) - 1;
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_pulse();
    start = 1'b1; cand_valid = 1'b1; ref_valid = 1'b1;
    @(negedge clk);
    chk(!cand_ready && !ref_ready, "R5 no beat in start cycle", cand_ready, 0);
    @(posedge clk); #1;
    start = 1'b0; cand_valid = 1'b0; ref_valid = 1'b0;
    esum = 0;
  endtask

  // mode 0 random, 1 identical, 2 worst case (0 vs 255)
  task automatic feed(int n, int mode, bit with_last);
    for (int i = 0; i < n; i++) begin
      logic [PW-1:0] c, r;
      bit taken = 0;
      c = PW'($urandom);
      r = (mode == 1) ? c : PW'($urandom);
      if (mode == 2) begin c = '0; r = '1; end
      while (!taken) begin
        cand_valid = ($urandom % 4) != 0;
        ref_valid  = ($urandom % 4) != 0;
        cand_pix = c; ref_pix = r;
        cand_last = with_last && (i == n - 1);
        @(negedge clk);
        if (cand_valid && ref_valid)
          chk(cand_ready && ref_ready, "R2 joined ready", cand_ready, 1);
        else
          chk(!cand_ready && !ref_ready, "R2 ready waits for both", cand_ready, 0);
        @(posedge clk); #1;
        taken = cand_valid && ref_valid;
      end
      esum += (c >= r) ? longint'(c - r) : longint'(r - c);
    end
    cand_valid = 1'b0; ref_valid = 1'b0; cand_last = 1'b0;
  endtask

  task automatic check_result(string tag);
    longint e = sat_to(esum, AW);
    @(negedge clk);
    chk(fitness == AW'(e), {tag, " R3 R6 fitness"}, fitness, e);
    chk(done == 1'b1, {tag, " R6 done"}, done, 1);
    chk(recovered == (e == 0), {tag, " R8 recovered"}, recovered, e == 0);
    chk(exceed == (e > longint'(threshold)), {tag, " R9 exceed"}, exceed, e > longint'(threshold));
    chk(s_fit == AWS'(sat_to(esum, AWS)), {tag, " R4 saturated fitness"}, s_fit, sat_to(esum, AWS));
  endtask

  task automatic read_pulse();
    logic [AW-1:0] keep = fitness;
    result_rd = 1'b1;
    @(posedge clk); #1;
    result_rd = 1'b0;
    @(negedge clk);
    chk(!done && !recovered && !exceed, "R7 read clears flags", {done, recovered, exceed}, 0);
    chk(fitness == keep, "R7 fitness kept after read", fitness, keep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 0; cand_valid = 0; ref_valid = 0; cand_last = 0;
    cand_pix = 0; ref_pix = 0; threshold = 0; result_rd = 0; esum = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !recovered && !exceed && fitness == 0, "R1 reset outputs", fitness, 0);
    chk(!cand_ready && !ref_ready, "R1 reset readies", cand_ready, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: no frame open
    cand_valid = 1; ref_valid = 1;
    @(negedge clk);
    chk(!cand_ready && !ref_ready, "R2 idle ready low", cand_ready, 0);
    @(posedge clk); #1;
    cand_valid = 0; ref_valid = 0;

    // R4: worst-case pixels saturate the narrow copy
    threshold = 1000;
    start_pulse(); feed(5, 2, 1); check_result("sat");
    cand_valid = 1; ref_valid = 1;
    @(negedge clk);
    chk(!cand_ready, "R6 frame closed after last", cand_ready, 0);
    @(posedge clk); #1;
    cand_valid = 0; ref_valid = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done && fitness == 1275, "R7 result held", fitness, 1275);
    @(posedge clk); #1;
    read_pulse();

    // R8: identical streams
    threshold = 0;
    start_pulse(); feed(20, 1, 1); check_result("zero");
    @(posedge clk); #1; read_pulse();

    // R9: boundary at equality and one below
    threshold = 510;
    start_pulse(); feed(2, 2, 1); check_result("eq");
    chk(!exceed, "R9 equal is not above", exceed, 0);
    @(posedge clk); #1; read_pulse();
    threshold = 509;
    start_pulse(); feed(2, 2, 1); check_result("above");
    chk(exceed, "R9 one above", exceed, 1);
    @(posedge clk); #1; read_pulse();

    // random frames
    for (int k = 0; k < 10; k++) begin
      threshold = AW'($urandom % 6000);
      start_pulse(); feed(1 + int'($urandom % 40), 0, 1); check_result("rand");
      @(posedge clk); #1; read_pulse();
    end

    // R10 and R5: partial sum above threshold raises nothing; restart discards it
    threshold = 100;
    start_pulse(); feed(3, 2, 0);
    @(negedge clk);
    chk(!done && !exceed && !recovered, "R10 no flag from partial sum", exceed, 0);
    @(posedge clk); #1;
    start_pulse(); feed(4, 1, 1); check_result("restart");
    chk(fitness == 0, "R5 restart cleared total", fitness, 0);

    // R10: overwrite an unread result
    @(posedge clk); #1;
    start_pulse(); feed(1, 2, 1); check_result("overwrite");
    chk(fitness == 255 && !recovered && exceed, "R10 overwrite", fitness, 255);
    @(posedge clk); #1; read_pulse();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule